// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and a 256-word by 4-bit asynchronous static RAM. The RAM has no clock. It has separate input and output data buses, a low-true select, a high-true select, a low-true write strobe and a low-true output enable. The host issues single-cycle requests over a valid/ready handshake. Each request carries a direction, an 8-bit address and 4 bits of write data. The sequencer turns each request into a RAM cycle with three phases: setup, strobe and hold. Each phase lasts a whole number of clock cycles, and that number is a parameter. The strobe phase pulses the write strobe for a write and opens the output enable for a read.

When a read finishes, the sequencer returns the captured word along with a one-cycle valid pulse. It then spends one more cycle with the RAM deselected and becomes ready again. While a cycle is in progress, the host keeps its request pending and waits for ready. Nothing the host drives during that time reaches the RAM pins.

Top module: `sram_access_ctl`

## Requirements
- R1: While `ready` is 1, the RAM pins are parked: `ram_sel_n`=1, `ram_sel`=0, `ram_we_n`=1, `ram_oe_n`=1. After reset, `ready` is 1 and `rd_valid` is 0.
- R2: Both selects are active together (`ram_sel_n`=0 and `ram_sel`=1) for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles per access, and never at any other time.
- R3: In a write, `ram_we_n` goes low only after SETUP_CYC selected cycles. It then stays low for exactly PULSE_CYC cycles. For HOLD_CYC cycles after it rises, the address, write data and selects do not change.
- R4: `ram_oe_n` is never 0 while `ram_we_n` is 0, and it stays 1 for the whole of a write access.
- R5: In a read, `ram_we_n` stays 1 and `ram_oe_n` is 0 for exactly PULSE_CYC cycles. The word on `ram_dout` in the last of those cycles is the word returned.
- R6: `rd_valid` is 1 for a single cycle, exactly SETUP_CYC+PULSE_CYC+HOLD_CYC+1 cycles after the accepting edge. In that cycle `rd_data` holds the word stored at the requested address. `rd_valid` never rises for a write.
- R7: A request is accepted only on an edge where `ready` is 1. `ready` is 0 from acceptance until SETUP_CYC+PULSE_CYC+HOLD_CYC+2 cycles after it. A request held valid during that time is served afterwards and is not lost.
- R8: The address, direction and write data are captured at acceptance. Changes on the request inputs after acceptance do not reach the RAM pins for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Sequencer idle; a request is accepted on this edge |
| rd_data | output | 4 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| ram_addr | output | 8 | RAM address bus |
| ram_din | output | 4 | RAM data input bus |
| ram_dout | input | 4 | RAM data output bus |
| ram_sel_n | output | 1 | Low-true chip select |
| ram_sel | output | 1 | High-true chip select |
| ram_we_n | output | 1 | Low-true write strobe |
| ram_oe_n | output | 1 | Low-true output enable |

## Verification
The bench uses unequal phase lengths and measures the write strobe width and the read output-enable width on every access. A phase counter that is off by one shows up as a wrong width. The RAM model drives unknown data whenever its output is disabled, so a capture taken in the hold cycle instead of the last strobe cycle returns garbage rather than the stored word. The bench keeps a second request valid through an access and counts the cycles with `ready` low. A design that re-accepts early would corrupt the first access, and one that drops the pending request would never return its data. A further test changes the request inputs just after acceptance, which exposes a design that drives the RAM address straight from the host instead of from a held copy.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
  } pin_ctl_t;

  // Pin levels for every sequencer state; the strobe phase picks WE or OE.
  function automatic pin_ctl_t pins_for(seq_state_e st, logic is_wr);
    pin_ctl_t p;
    p = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1};
    case (st)
      ST_SETUP, ST_HOLD: begin
        p.sel_n = 1'b0;
        p.sel   = 1'b1;
      end
      ST_STROBE: begin
        p.sel_n = 1'b0;
        p.sel   = 1'b1;
        p.we_n  = ~is_wr;
        p.oe_n  = is_wr;
      end
      default: ;
    endcase
    return p;
  endfunction

  // Cycles from the accepting edge to the rd_valid cycle.
  function automatic int unsigned access_latency(int unsigned s, int unsigned p, int unsigned h);
    return s + p + h + 1;
  endfunction

  // Counter width that holds the longest phase.
  function automatic int unsigned phase_cnt_width(int unsigned s, int unsigned p, int unsigned h);
    int unsigned m;
    m = s;
    if (p > m) m = p;
    if (h > m) m = h;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len != '0)); // R3

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             phase_last,
  output seq_state_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len
);

  localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] PULSE_LEN = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] HOLD_LEN  = CNT_W'(HOLD_CYC);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = SETUP_LEN;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_len  = SETUP_LEN;
      end
      ST_SETUP: if (phase_last) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_len  = PULSE_LEN;
      end
      ST_STROBE: if (phase_last) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_len  = HOLD_LEN;
      end
      ST_HOLD: if (phase_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_SETUP || $past(state_q) == ST_SETUP)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/sram_req_regs.sv
module sram_req_regs #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_word,
  output logic          op_write,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      op_write <= req_write;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_word;
  end

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(addr_q) && $stable(wdata_q) && $stable(op_write))); // R8

endmodule

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [3:0] req_wdata,
  output logic       ready,
  output logic [3:0] rd_data,
  output logic       rd_valid,
  output logic [7:0] ram_addr,
  output logic [3:0] ram_din,
  input  logic [3:0] ram_dout,
  output logic       ram_sel_n,
  output logic       ram_sel,
  output logic       ram_we_n,
  output logic       ram_oe_n
);

  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 4;
  localparam int unsigned CNT_W = phase_cnt_width(SETUP_CYC, PULSE_CYC, HOLD_CYC);

  seq_state_e       state;
  logic             phase_last;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             op_write;
  pin_ctl_t         pins;

  // Named internal events
  logic accept_evt;
  logic capture_evt;

  assign ready       = (state == ST_IDLE);
  assign accept_evt  = ready && req_valid;
  assign capture_evt = (state == ST_STROBE) && phase_last && !op_write;

  sram_seq_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CNT_W     (CNT_W)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept_evt),
    .phase_last (phase_last),
    .state      (state),
    .tmr_load   (tmr_load),
    .tmr_len    (tmr_len)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .last     (phase_last)
  );

  sram_req_regs #(.AW(AW), .DW(DW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_evt),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture_evt),
    .mem_word  (ram_dout),
    .op_write  (op_write),
    .addr_q    (ram_addr),
    .wdata_q   (ram_din),
    .rdata_q   (rd_data)
  );

  assign pins      = pins_for(state, op_write);
  assign ram_sel_n = pins.sel_n;
  assign ram_sel   = pins.sel;
  assign ram_we_n  = pins.we_n;
  assign ram_oe_n  = pins.oe_n;
  assign rd_valid  = (state == ST_DONE) && !op_write;

  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ram_sel_n && !ram_sel && ram_we_n && ram_oe_n)); // R1
  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_sel_n && ram_sel)); // R2
  AST_SEL_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel_n == !ram_sel); // R2
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n)); // R4
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |=> ($stable(ram_addr) && $stable(ram_din) && !ram_sel_n)); // R3
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !ready); // R7

endmodule

// File: tb/test_sram_access_ctl.sv
module test_sram_access_ctl;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned S_CYC = 2;
  localparam int unsigned P_CYC = 3;
  localparam int unsigned H_CYC = 1;
  localparam int unsigned RDV_AT = S_CYC + P_CYC + H_CYC + 1;
  localparam int unsigned RDY_AT = S_CYC + P_CYC + H_CYC + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic       ready, rd_valid;
  logic [3:0] rd_data;
  logic [7:0] ram_addr;
  logic [3:0] ram_din, ram_dout;
  logic       ram_sel_n, ram_sel, ram_we_n, ram_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_access_ctl #(.SETUP_CYC(S_CYC), .PULSE_CYC(P_CYC), .HOLD_CYC(H_CYC)) i_sram_access_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .ram_addr(ram_addr), .ram_din(ram_din), .ram_dout(ram_dout),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  // Behavioural asynchronous RAM: stores at the end of the strobe, drives X when disabled.
  logic [3:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = 4'(i ^ (i >> 4));
  always @(posedge ram_we_n) if (!ram_sel_n && ram_sel) ram[ram_addr] <= ram_din;
  assign ram_dout = (!ram_sel_n && ram_sel && ram_we_n && !ram_oe_n) ? ram[ram_addr] : 4'bx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin monitor sampled at the falling edge
  int sel_run = 0, we_run = 0, oe_run = 0, pre_we = 0, hold_run = 0;
  bit in_write_hold = 1'b0;
  logic [7:0] pulse_addr;
  logic [3:0] pulse_din;
  always @(negedge clk) if (rst_n && !done) begin
    if (!ram_sel_n && ram_sel) begin
      sel_run++;
      if (ram_we_n && we_run == 0 && !in_write_hold) pre_we++;
    end else if (sel_run != 0) begin
      chk(sel_run == S_CYC + P_CYC + H_CYC, "R2 select window", sel_run, S_CYC + P_CYC + H_CYC);
      sel_run = 0; pre_we = 0;
    end
    if (ram_sel_n == ram_sel) chk(0, "R2 select polarity", ram_sel, !ram_sel_n);
    if (!ram_we_n) begin
      if (we_run == 0) chk(pre_we == S_CYC, "R3 setup before strobe", pre_we, S_CYC);
      else chk(ram_addr == pulse_addr && ram_din == pulse_din, "R3 stable in pulse", ram_addr, pulse_addr);
      pulse_addr = ram_addr; pulse_din = ram_din;
      we_run++;
      if (!ram_oe_n) chk(0, "R4 oe during write", ram_oe_n, 1);
    end else if (we_run != 0) begin
      chk(we_run == P_CYC, "R3 strobe width", we_run, P_CYC);
      we_run = 0; in_write_hold = 1'b1; hold_run = 0;
    end
    if (in_write_hold) begin
      if (!ram_sel_n) begin
        hold_run++;
        chk(ram_addr == pulse_addr && ram_din == pulse_din && ram_oe_n, "R3 hold stable", ram_addr, pulse_addr);
      end else begin
        chk(hold_run == H_CYC, "R3 hold length", hold_run, H_CYC);
        in_write_hold = 1'b0;
      end
    end
    if (!ram_oe_n) oe_run++;
    else if (oe_run != 0) begin
      chk(oe_run == P_CYC, "R5 oe width", oe_run, P_CYC);
      oe_run = 0;
    end
    if (ready) chk(ram_sel_n && !ram_sel && ram_we_n && ram_oe_n, "R1 parked", {ram_sel_n, ram_sel, ram_we_n, ram_oe_n}, 4'b1011);
  end

  // Issue one request; returns read data and cycle positions of rd_valid and ready.
  task automatic do_op(input bit wr, input logic [7:0] a, input logic [3:0] d,
                       output logic [3:0] rdat, output int rdv_n, output int rdy_n, input bit keep_next = 0);
    int n;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    if (!keep_next) req_valid = 1'b0;
    n = 1; rdv_n = -1; rdat = 'x;
    while (!ready) begin
      if (rd_valid) begin
        chk(rdv_n == -1, "R6 single pulse", n, rdv_n);
        rdv_n = n; rdat = rd_data;
      end
      @(negedge clk); n++;
    end
    rdy_n = n;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    chk(ram_sel_n && !ram_sel && ram_we_n && ram_oe_n, "R1 pins after reset",
        {ram_sel_n, ram_sel, ram_we_n, ram_oe_n}, 4'b1011);
  endtask

  task automatic t_write_read(input logic [7:0] a, input logic [3:0] d);
    logic [3:0] r; int v, y;
    do_op(1'b1, a, d, r, v, y);
    chk(v == -1, "R6 no rd_valid on write", v, -1);
    chk(y == RDY_AT, "R7 ready after write", y, RDY_AT);
    do_op(1'b0, a, 4'h0, r, v, y);
    chk(v == RDV_AT, "R6 rd_valid timing", v, RDV_AT);
    chk(r === d, "R5 read data", r, d);
    chk(y == RDY_AT, "R7 ready after read", y, RDY_AT);
  endtask

  task automatic t_preloaded;
    logic [3:0] r; int v, y;
    do_op(1'b0, 8'hC3, 4'h0, r, v, y);
    chk(r === 4'(8'hC3 ^ 8'h0C), "R5 preloaded word", r, 4'(8'hC3 ^ 8'h0C));
  endtask

  task automatic t_holdoff;
    logic [3:0] r; int v, y;
    int busy;
    // write then, with valid kept high, a read queued behind it
    do_op(1'b1, 8'h77, 4'h9, r, v, y, 1'b1);
    chk(y == RDY_AT, "R7 busy length with pending request", y, RDY_AT);
    req_write = 1'b0; req_addr = 8'h77;
    busy = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!ready) begin
      if (rd_valid) r = rd_data;
      busy++;
      @(negedge clk);
    end
    chk(busy == RDY_AT - 1, "R7 pending request served", busy, RDY_AT - 1);
    chk(r === 4'h9, "R7 pending read data", r, 4'h9);
  endtask

  task automatic t_latch;
    logic [3:0] r; int v, y;
    req_write = 1'b1; req_addr = 8'h5A; req_wdata = 4'h3; req_valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 8'hA5; req_wdata = 4'hE; req_write = 1'b0;
    @(negedge clk);
    chk(ram_addr == 8'h5A, "R8 address held", ram_addr, 8'h5A);
    while (!ready) @(negedge clk);
    do_op(1'b0, 8'h5A, 4'h0, r, v, y);
    chk(r === 4'h3, "R8 write data held", r, 4'h3);
    do_op(1'b0, 8'hA5, 4'h0, r, v, y);
    chk(r === 4'(8'hA5 ^ 8'h0A), "R8 other word untouched", r, 4'(8'hA5 ^ 8'h0A));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read(8'h00, 4'hF);
    t_write_read(8'hFF, 4'h0);
    t_write_read(8'h3C, 4'hA);
    t_write_read(8'h81, 4'h5);
    t_preloaded();
    t_holdoff();
    t_latch();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule